// File: doc/BRIEF.md
# Two-Mode Serial Shift Engine

This block moves serial data in and out of a chip over a two-wire link. It has two modes. In clocked synchronous mode an external clock strobes a data input, and a separate push-pull data output changes on the opposite clock edge. In I2C mode the same two input lines are read as SCL and SDA. The block takes part in byte transfers as an open-drain device: it can pull SDA low but never drives it high. Each transfer is eight data bits plus a ninth acknowledge bit. The block never drives the clock line in either mode.

Received bits collect in a shift register. They are copied into a 9-bit receive buffer at points that depend on the mode bits. In clocked synchronous mode the order is least significant bit first. In I2C mode it is most significant bit first. Four sticky event flags report the bus events: a received byte, an acknowledge, a not-acknowledge, and a bus condition (START or STOP).

Each line passes through a synchronizer and then a glitch filter. The filter is short in clocked synchronous mode and long in I2C mode. Software writes the four mode bits with a single strobe. That write also clears every flag and restarts the bit count, so a mode change never leaves a stale request behind. Configure the block only while the lines sit at their idle levels.

Top module: `dmser_shifter`

## Requirements
- R1: In clocked synchronous mode, received bit k (k = 1..8) lands in buffer bit k-1. After the 8th sample edge the buffer holds {0, byte} and flag bit 0 (receive) is set.
- R2: In clocked synchronous mode, cfg_pol_i = 0 samples on the rising clock edge and cfg_pol_i = 1 samples on the falling edge. txd_o presents transmit bit 0 first and moves to the next bit on the edge opposite the sampling edge, with no added delay.
- R3: In I2C mode with cfg_evsel_i = 0, the first received bit goes to buffer bit 7 and the eighth to bit 0. On the 9th SCL rising edge the buffer takes {SDA, byte}. SDA low sets flag bit 1 (ACK) and SDA high sets flag bit 2 (NACK). The receive flag is not set.
- R4: In I2C mode, SDA falling or rising while SCL is high (START or STOP) sets flag bit 3, whatever the event selection. This flag is never set in clocked synchronous mode.
- R5: In I2C mode with cfg_evsel_i = 1 and cfg_cdly_i = 0, the buffer takes {ninth bit, byte} on the SCL falling edge that ends the 9th bit, and the receive flag is set. The ACK and NACK flags stay clear.
- R6: In I2C mode with cfg_evsel_i = 1 and cfg_cdly_i = 1, the falling SCL edge after the 8th bit loads {bit 8, 0, bits 1..7} into buffer bits 8, 7 and 6..0, and sets the receive flag. The 9th rising edge then reloads {ninth bit, byte}.
- R7: A line pulse of one system clock is ignored in clocked synchronous mode. In I2C mode a pulse shorter than 8 clocks is ignored, and one of 8 or more clocks is accepted.
- R8: In I2C mode, sda_oe_o = 1 pulls SDA low. The transmit byte goes out most significant bit first, followed by tx_ack_i. Each new bit appears SDA_DLY clocks after the SCL falling edge is detected, and SDA is released after the 9th bit. In clocked synchronous mode sda_oe_o stays 0.
- R9: A write on cfg_wr_i clears all four flags and the bit count. A bit set in ev_clr_i clears the matching flag.
- R10: After reset the flags and the buffer are zero, sda_oe_o is 0 and txd_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Strobe that writes the four mode bits |
| cfg_i2c_i | input | 1 | 1 selects I2C mode, 0 selects clocked synchronous mode |
| cfg_pol_i | input | 1 | Sampling edge in clocked synchronous mode (0 rising, 1 falling) |
| cfg_evsel_i | input | 1 | I2C event selection (0 ACK/NACK, 1 transmit/receive) |
| cfg_cdly_i | input | 1 | I2C clock-delay load timing |
| ev_clr_i | input | 4 | Per-flag clear mask |
| tx_load_i | input | 1 | Loads the transmit shifter |
| tx_data_i | input | DATA_W | Transmit byte |
| tx_ack_i | input | 1 | Ninth bit sent in I2C mode (0 means acknowledge) |
| line_clk_i | input | 1 | Serial clock line or SCL |
| line_dat_i | input | 1 | Serial data input or SDA |
| txd_o | output | 1 | Serial data output, clocked synchronous mode |
| sda_oe_o | output | 1 | SDA pull-low enable, I2C mode |
| rbuf_o | output | DATA_W+1 | Receive buffer |
| ev_flags_o | output | 4 | Flags: 0 receive, 1 ACK, 2 NACK, 3 bus condition |

## Verification
In clocked synchronous mode every byte value is received under both polarities, while a different byte is transmitted at the same time. This separates bit order from edge choice. Some of these bytes carry a one-clock glitch on the clock line, which would otherwise add an extra shift. The I2C transfers walk through the three load-timing selections. Each one pairs a received byte with a transmitted byte, and the two are combined on the wired-AND bus, so sampling, open-drain driving and the split or full buffer layout all show up in the buffer value. Master acknowledge levels alternate to tell ACK from NACK. SDA pulses of 7 and 9 clocks bracket the I2C filter length.

// File: rtl/dmser_pkg.sv
package dmser_pkg;
  typedef struct packed {
    logic i2c;
    logic pol;
    logic evsel;
    logic cdly;
  } dmser_cfg_t;

  localparam int EV_RX   = 0;
  localparam int EV_ACK  = 1;
  localparam int EV_NACK = 2;
  localparam int EV_COND = 3;
  localparam int EV_W    = 4;
endpackage

// File: rtl/dmser_glitch_filter.sv
module dmser_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_RUN   = 2,
  parameter int LONG_RUN    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic long_i,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(LONG_RUN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_s;
  logic [CW-1:0]          run_q, run_d, need;
  logic                   filt_q, filt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end
  assign sync_s = sync_q[SYNC_STAGES-1];

  assign need = long_i ? CW'(LONG_RUN) : CW'(SHORT_RUN);

  // the synchronized level must differ from the output for `need` samples in a row
  always_comb begin
    run_d  = '0;
    filt_d = filt_q;
    if (sync_s != filt_q) begin
      if (run_q + 1'b1 >= need) filt_d = sync_s;
      else                      run_d  = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      run_q  <= run_d;
      filt_q <= filt_d;
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/dmser_line_events.sv
module dmser_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic i2c_i,
  input  logic clk_f_i,
  input  logic dat_f_i,
  output logic rise_o,
  output logic fall_o,
  output logic cond_o
);
  logic clk_d_q, dat_d_q;
  logic start_s, stop_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d_q <= 1'b1;
      dat_d_q <= 1'b1;
    end else begin
      clk_d_q <= clk_f_i;
      dat_d_q <= dat_f_i;
    end
  end

  assign rise_o  = clk_f_i & ~clk_d_q;
  assign fall_o  = ~clk_f_i & clk_d_q;
  // conditions need SCL high in both the previous and the current sample
  assign start_s = clk_f_i & clk_d_q & dat_d_q & ~dat_f_i;
  assign stop_s  = clk_f_i & clk_d_q & ~dat_d_q & dat_f_i;
  assign cond_o  = i2c_i & (start_s | stop_s);
endmodule

// File: rtl/dmser_rx_ctrl.sv
module dmser_rx_ctrl
  import dmser_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dmser_cfg_t      cfg_i,
  input  logic            restart_i,
  input  logic            cond_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            dat_i,
  output logic [DW:0]     rbuf_o,
  output logic [EV_W-1:0] ev_set_o,
  output logic            armed_o
);
  localparam int CNTW = $clog2(DW + 2);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [DW-1:0]   sh_q, sh_d;
  logic [DW:0]     buf_q, buf_d;
  logic            ninth_q, ninth_d;
  logic [EV_W-1:0] set_s;
  logic            smp_sync;

  assign smp_sync = cfg_i.pol ? fall_i : rise_i;

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    buf_d   = buf_q;
    ninth_d = ninth_q;
    set_s   = '0;
    if (restart_i || (cfg_i.i2c && cond_i)) begin
      cnt_d = '0;
    end else if (!cfg_i.i2c) begin
      // clocked synchronous: LSB first, load after the last data bit
      if (smp_sync) begin
        sh_d = {dat_i, sh_q[DW-1:1]};
        if (cnt_q == CNTW'(DW - 1)) begin
          cnt_d        = '0;
          buf_d        = {1'b0, dat_i, sh_q[DW-1:1]};
          set_s[EV_RX] = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (rise_i) begin
      if (cnt_q < CNTW'(DW)) begin
        sh_d  = {sh_q[DW-2:0], dat_i};
        cnt_d = cnt_q + 1'b1;
      end else if (cnt_q == CNTW'(DW)) begin
        cnt_d   = CNTW'(DW + 1);
        ninth_d = dat_i;
        if (!cfg_i.evsel) begin
          buf_d = {dat_i, sh_q};
          if (dat_i) set_s[EV_NACK] = 1'b1;
          else       set_s[EV_ACK]  = 1'b1;
        end else if (cfg_i.cdly) begin
          buf_d = {dat_i, sh_q};
        end
      end
    end else if (fall_i) begin
      if (cnt_q == CNTW'(DW) && cfg_i.evsel && cfg_i.cdly) begin
        buf_d        = {sh_q[0], 1'b0, sh_q[DW-1:1]};
        set_s[EV_RX] = 1'b1;
      end else if (cnt_q == CNTW'(DW + 1)) begin
        cnt_d = '0;
        if (cfg_i.evsel && !cfg_i.cdly) begin
          buf_d        = {ninth_q, sh_q};
          set_s[EV_RX] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      buf_q   <= '0;
      ninth_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      buf_q   <= buf_d;
      ninth_q <= ninth_d;
    end
  end

  assign rbuf_o   = buf_q;
  assign ev_set_o = set_s;
  assign armed_o  = (cnt_q != '0);
endmodule

// File: rtl/dmser_tx_shift.sv
module dmser_tx_shift #(
  parameter int DW      = 8,
  parameter int SDA_DLY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i2c_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          ack_i,
  input  logic          drive_i,
  input  logic          fall_i,
  input  logic          armed_i,
  output logic          txd_o,
  output logic          sda_oe_o
);
  localparam int DLYW = $clog2(SDA_DLY + 1);

  logic [DW:0]     sh_q, sh_d;
  logic [DLYW-1:0] dly_q, dly_d;

  always_comb begin
    sh_d  = sh_q;
    dly_d = dly_q;
    if (load_i) begin
      sh_d  = i2c_i ? {data_i, ack_i} : {1'b1, data_i};
      dly_d = '0;
    end else if (!i2c_i) begin
      if (drive_i && armed_i) sh_d = {1'b1, sh_q[DW:1]};
    end else if (fall_i && armed_i) begin
      dly_d = DLYW'(SDA_DLY);
    end else if (dly_q != '0) begin
      dly_d = dly_q - 1'b1;
      if (dly_q == DLYW'(1)) sh_d = {sh_q[DW-1:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      dly_q <= '0;
    end else begin
      sh_q  <= sh_d;
      dly_q <= dly_d;
    end
  end

  assign txd_o    = i2c_i ? 1'b1 : sh_q[0];
  assign sda_oe_o = i2c_i & ~sh_q[DW];
endmodule

// File: rtl/dmser_shifter.sv
module dmser_shifter
  import dmser_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_SHORT  = 2,
  parameter int FILT_LONG   = 8,
  parameter int SDA_DLY     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic              cfg_i2c_i,
  input  logic              cfg_pol_i,
  input  logic              cfg_evsel_i,
  input  logic              cfg_cdly_i,
  input  logic [EV_W-1:0]   ev_clr_i,
  input  logic              tx_load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_ack_i,
  input  logic              line_clk_i,
  input  logic              line_dat_i,
  output logic              txd_o,
  output logic              sda_oe_o,
  output logic [DATA_W:0]   rbuf_o,
  output logic [EV_W-1:0]   ev_flags_o
);
  localparam int NLINES = 2;

  dmser_cfg_t      cfg_q, cfg_d;
  logic [EV_W-1:0] ev_q, ev_d, ev_set, rx_set;
  logic [NLINES-1:0] line_raw, line_flt;
  logic rise_s, fall_s, cond_s, armed_s, drive_s;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr_i) begin
      cfg_d.i2c   = cfg_i2c_i;
      cfg_d.pol   = cfg_pol_i;
      cfg_d.evsel = cfg_evsel_i;
      cfg_d.cdly  = cfg_cdly_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign line_raw = {line_dat_i, line_clk_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    dmser_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .SHORT_RUN  (FILT_SHORT),
      .LONG_RUN   (FILT_LONG)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .long_i(cfg_q.i2c),
      .line_i(line_raw[g]),
      .line_o(line_flt[g])
    );
  end

  dmser_line_events u_events (
    .clk    (clk),
    .rst_n  (rst_n),
    .i2c_i  (cfg_q.i2c),
    .clk_f_i(line_flt[0]),
    .dat_f_i(line_flt[1]),
    .rise_o (rise_s),
    .fall_o (fall_s),
    .cond_o (cond_s)
  );

  dmser_rx_ctrl #(.DW(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_i    (cfg_q),
    .restart_i(cfg_wr_i),
    .cond_i   (cond_s),
    .rise_i   (rise_s),
    .fall_i   (fall_s),
    .dat_i    (line_flt[1]),
    .rbuf_o   (rbuf_o),
    .ev_set_o (rx_set),
    .armed_o  (armed_s)
  );

  assign drive_s = ~cfg_q.i2c & (cfg_q.pol ? rise_s : fall_s);

  dmser_tx_shift #(.DW(DATA_W), .SDA_DLY(SDA_DLY)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .i2c_i   (cfg_q.i2c),
    .load_i  (tx_load_i),
    .data_i  (tx_data_i),
    .ack_i   (tx_ack_i),
    .drive_i (drive_s),
    .fall_i  (fall_s),
    .armed_i (armed_s),
    .txd_o   (txd_o),
    .sda_oe_o(sda_oe_o)
  );

  always_comb begin
    ev_set          = rx_set;
    ev_set[EV_COND] = cond_s;
    if (cfg_wr_i) ev_d = '0;
    else          ev_d = (ev_q & ~ev_clr_i) | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end

  assign ev_flags_o = ev_q;
endmodule

// File: rtl/dmser_shifter_chk.sv
module dmser_shifter_chk
  import dmser_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic            i2c,
  input logic            evsel,
  input logic [EV_W-1:0] flags,
  input logic [DW:0]     rbuf,
  input logic            sda_oe
);
  assert_cfg_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (flags == '0));

  assert_sync_no_pull_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !i2c |-> !sda_oe);

  assert_no_cond_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(i2c) |-> !$rose(flags[EV_COND]));

  assert_ack_nack_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(flags[EV_ACK]) && $rose(flags[EV_NACK])));

  assert_ack_needs_evsel0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[EV_ACK]) || $rose(flags[EV_NACK])) |-> !$past(evsel));

  assert_sync_top_bit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[EV_RX]) && !$past(i2c)) |-> (rbuf[DW] == 1'b0));
endmodule

bind dmser_shifter dmser_shifter_chk #(.DW(DATA_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cfg_wr(cfg_wr_i),
  .i2c   (cfg_q.i2c),
  .evsel (cfg_q.evsel),
  .flags (ev_flags_o),
  .rbuf  (rbuf_o),
  .sda_oe(sda_oe_o)
);

// File: tb/dmser_shifter_bench.sv
module dmser_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HS = 8;
  localparam int HI = 20;
  localparam int WDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_i2c = 1'b0, cfg_pol = 1'b0, cfg_evsel = 1'b0, cfg_cdly = 1'b0;
  logic [3:0] ev_clr = '0;
  logic       tx_load = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ack = 1'b1;
  logic       lclk = 1'b1, ldat = 1'b1, sdam = 1'b1;
  logic       txd, sda_oe;
  logic [8:0] rbuf;
  logic [3:0] flags;
  logic       i2c_bus = 1'b0;
  logic       line_dat;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND bus in I2C mode
  assign line_dat = i2c_bus ? (sdam & ~sda_oe) : ldat;

  dmser_shifter u_dmser_shifter (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_i(cfg_wr), .cfg_i2c_i(cfg_i2c), .cfg_pol_i(cfg_pol),
    .cfg_evsel_i(cfg_evsel), .cfg_cdly_i(cfg_cdly),
    .ev_clr_i(ev_clr), .tx_load_i(tx_load), .tx_data_i(tx_data), .tx_ack_i(tx_ack),
    .line_clk_i(lclk), .line_dat_i(line_dat),
    .txd_o(txd), .sda_oe_o(sda_oe), .rbuf_o(rbuf), .ev_flags_o(flags)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic i2c, input logic pol, input logic evsel, input logic cdly);
    @(negedge clk);
    cfg_i2c = i2c; cfg_pol = pol; cfg_evsel = evsel; cfg_cdly = cdly; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic load_tx(input logic [7:0] d, input logic a);
    @(negedge clk);
    tx_data = d; tx_ack = a; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  // clocked synchronous byte: R1, R2 (and R7 when a glitch is inserted)
  task automatic sync_byte(input logic pol, input logic [7:0] v, input logic [7:0] tv, input bit glitch);
    logic idle;
    bit   tx_ok;
    idle = ~pol;
    i2c_bus = 1'b0;
    lclk = idle; ldat = 1'b1;
    wait_n(8);
    set_cfg(1'b0, pol, 1'b0, 1'b0);
    load_tx(tv, 1'b1);
    wait_n(2);
    tx_ok = 1;
    for (int i = 0; i < 8; i++) begin
      lclk = ~idle; ldat = v[i];
      wait_n(HS);
      if (txd !== tv[i]) tx_ok = 0;
      if (glitch && i == 3) begin
        lclk = idle; wait_n(1); lclk = ~idle; wait_n(HS);
      end
      lclk = idle;
      wait_n(HS);
    end
    chk("R2 txd bit sequence", {15'd0, tx_ok}, 16'd1);
    chk(glitch ? "R7 sync glitch buffer" : "R1 sync buffer", {7'd0, rbuf}, {8'd0, v});
    chk(pol ? "R2 falling-edge flags" : "R1 rising-edge flags", {12'd0, flags}, 16'h0001);
  endtask

  // I2C byte: mode 0 = ACK/NACK events, 1 = tx/rx no delay, 2 = tx/rx with clock delay
  task automatic i2c_byte(input int mode, input logic [7:0] v, input logic [7:0] tv,
                          input logic tack, input logic mack);
    logic [7:0] rx;
    logic       b9, bit_m, bit_t;
    bit         oe_ok, dly_ok;
    rx = v & tv;
    b9 = mack & tack;
    i2c_bus = 1'b1;
    lclk = 1'b1; sdam = 1'b1;
    wait_n(HI);
    set_cfg(1'b1, 1'b0, mode != 0, mode == 2);
    wait_n(HI);
    sdam = 1'b0;                       // START
    wait_n(HI);
    chk("R4 start flag", {12'd0, flags}, 16'h0008);
    @(negedge clk); ev_clr = 4'b1000;
    @(negedge clk); ev_clr = 4'b0000;
    chk("R9 selective clear", {12'd0, flags}, 16'h0000);
    lclk = 1'b0;
    wait_n(HI);
    load_tx(tv, tack);
    oe_ok = 1; dly_ok = 1;
    for (int i = 0; i < 9; i++) begin
      bit_m = (i < 8) ? v[7-i] : mack;
      bit_t = (i < 8) ? tv[7-i] : tack;
      sdam = bit_m;
      wait_n(HI);
      lclk = 1'b1;
      wait_n(HI);
      if (sda_oe !== ~bit_t) oe_ok = 0;
      if (i == 8 && mode == 0) begin
        chk("R3 ninth-rise buffer", {7'd0, rbuf}, {7'd0, b9, rx});
        chk("R3 ack/nack flag", {12'd0, flags}, b9 ? 16'h0004 : 16'h0002);
      end
      if (i == 8 && mode == 2) begin
        chk("R6 reload buffer", {7'd0, rbuf}, {7'd0, b9, rx});
        chk("R6 flags after reload", {12'd0, flags}, 16'h0001);
      end
      lclk = 1'b0;
      wait_n(12);
      if (sda_oe !== ~bit_t) dly_ok = 0;
      wait_n(HI - 12);
      if (i == 7 && mode == 2) begin
        chk("R6 split buffer", {7'd0, rbuf}, {7'd0, rx[0], 1'b0, rx[7:1]});
        chk("R6 split flags", {12'd0, flags}, 16'h0001);
      end
      if (i == 8 && mode == 1) begin
        chk("R5 ninth-fall buffer", {7'd0, rbuf}, {7'd0, b9, rx});
        chk("R5 flags", {12'd0, flags}, 16'h0001);
      end
    end
    chk("R8 sda drive sequence", {15'd0, oe_ok}, 16'd1);
    chk("R8 sda output delay", {15'd0, dly_ok}, 16'd1);
    chk("R8 sda released", {15'd0, sda_oe}, 16'd0);
    sdam = 1'b0; wait_n(HI);
    lclk = 1'b1; wait_n(HI);
    sdam = 1'b1; wait_n(HI);            // STOP
    chk("R4 stop flag", {15'd0, flags[3]}, 16'd1);
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    chk("R10 reset flags", {12'd0, flags}, 16'h0000);
    chk("R10 reset buffer", {7'd0, rbuf}, 16'h0000);
    chk("R10 reset sda_oe", {15'd0, sda_oe}, 16'd0);
    chk("R10 reset txd", {15'd0, txd}, 16'd1);

    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] tv;
        tv = 8'(v * 7 + 1);
        sync_byte(p[0], 8'(v), tv, v[4:0] == 5'd5);
      end
    end

    for (int k = 0; k < 37; k++) begin
      logic [7:0] v, tv;
      v  = 8'(k * 7);
      tv = ((k % 3) == 0) ? 8'hFF : (v ^ 8'hA5);
      i2c_byte(k % 3, v, tv, ((k / 3) % 2) == 0, ((k / 6) % 2) == 1);
    end

    // R9: mode write clears flags left by the last transfer
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
    wait_n(2);
    chk("R9 cfg write clears flags", {12'd0, flags}, 16'h0000);

    // R7: I2C filter length on SDA while SCL is high
    wait_n(HI);
    sdam = 1'b0; wait_n(7); sdam = 1'b1;
    wait_n(HI);
    chk("R7 seven-clock pulse ignored", {12'd0, flags}, 16'h0000);
    sdam = 1'b0; wait_n(9); sdam = 1'b1;
    wait_n(HI);
    chk("R7 nine-clock pulse accepted", {15'd0, flags[3]}, 16'd1);

    // R4: bus conditions ignored in clocked synchronous mode
    i2c_bus = 1'b0;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    lclk = 1'b1; ldat = 1'b1; wait_n(HS);
    ldat = 1'b0; wait_n(HS); ldat = 1'b1; wait_n(HS);
    chk("R4 no condition in sync mode", {15'd0, flags[3]}, 16'd0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule